// File: doc/BRIEF.md
# Adaptive Dual-LUT Logic Cell

This block models one configurable logic cell of a programmable fabric. Eight data inputs, a carry input, a shared-arithmetic input and a register-chain input feed four 16-entry lookup tables, a two-stage ripple adder and a pair of registers. A 2-bit mode field turns the same hardware into one of four data paths. The first is a pair of six-input functions that read one 64-entry table. The second is a seven-input function built as a 2:1 choice between two five-input functions. The third is a two-bit adder whose operands come from LUT pre-logic. The fourth is a three-operand adder in which LUTs produce per-bit sum and carry terms and pass the carry term on a second chain.

The configuration vector (`cfg_i`) is captured while `rst_ni` is low and is then frozen. Its bits [63:0] hold the tables: LUT k sits in bits [16k+15:16k], and each table is addressed by a 4-bit index. Bits [65:64] hold the mode (00 normal, 01 extended, 10 arithmetic, 11 shared arithmetic). Bit 66 makes the registers a shift chain. In `data_i`, bit 0 is a, 1 is b, 2 is c, 3 is d, 4 is e0, 5 is f0, 6 is e1 and 7 is f1. Cells are cascaded by wiring `carry_o`, `share_o` and `rchain_o` to the next cell's `carry_i`, `share_i` and `rchain_i`. Register enable, synchronous clear and synchronous load are shared control inputs supplied from outside the cell.

Top module: `dual_lut_cell`

## Requirements
- R1: `cfg_i` is loaded while `rst_ni` is low. Once `rst_ni` is high, changes on `cfg_i` have no effect on any output.
- R2: Let T be `cfg[63:0]`. In mode 00, `comb_o[0]` = T[{f0,e0,d,c,b,a}] and `comb_o[1]` = T[{f1,e1,d,c,b,a}], so both outputs read the same table through different select pairs. In this mode `carry_o` and `share_o` are 0.
- R3: In mode 01, `comb_o[0]` = f0 ? T[32+{e1,d,c,b,a}] : T[{e0,d,c,b,a}] and `comb_o[1]` = 0. Without the shift chain, an enabled clock edge leaves register 1 at 0.
- R4: In mode 10, L0 = LUT0[{f0,e0,b,a}], L1 = LUT1[{d,c,b,a}], L2 = LUT2[{f1,e1,b,a}] and L3 = LUT3[{d,c,b,a}]. The output {`carry_o`,`comb_o[1]`,`comb_o[0]`} equals L0+L1+`carry_i`+2·(L2+L3). With LUT0 = a, LUT1 = ~b, LUT2 = e1, LUT3 = ~c and `carry_i` = 1, `carry_o` is 1 exactly when {e1,a} ≥ {c,b}.
- R5: In mode 11, L0 = LUT0[{e0,c,b,a}], L1 = LUT1[{e0,c,b,a}], L2 = LUT2[{f1,e1,d,f0}] and L3 = LUT3[{f1,e1,d,f0}]. The output {`carry_o`,`comb_o`} equals L0+`share_i`+`carry_i`+2·(L2+L1), and `share_o` = L3.
- R6: When `ena_i` is 1 at a rising edge and the shift chain is off, `q_o` takes the `comb_o` value that was present before the edge. `comb_o` stays valid at the same time.
- R7: With `ena_i` high, `sclr_i` clears both registers and takes priority over `sload_i`. `sload_i` loads `sdata_i`.
- R8: With `ena_i` low, `q_o` holds whatever the other inputs do.
- R9: With `cfg[66]` set and the register enabled, each edge moves `rchain_i` into register 0 and register 0 into register 1. `rchain_o` follows register 1.
- R10: Driving `rst_ni` low clears `q_o` and `rchain_o` at once, without waiting for a clock.
- R11: Two cells in mode 11, chained through carry and shared-carry with both chain inputs of the low cell at 0, add three 3-bit operands exactly (for example 6+5+2 = 13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; loads configuration |
| cfg_i | input | 67 | Configuration vector (tables, mode, shift-chain enable) |
| data_i | input | 8 | LUT data inputs {f1,e1,f0,e0,d,c,b,a} |
| carry_i | input | 1 | Carry chain input |
| share_i | input | 1 | Shared-arithmetic chain input |
| rchain_i | input | 1 | Register chain input |
| ena_i | input | 1 | Register clock enable |
| sclr_i | input | 1 | Synchronous clear |
| sload_i | input | 1 | Synchronous load |
| sdata_i | input | 2 | Synchronous load data |
| comb_o | output | 2 | Unregistered results |
| q_o | output | 2 | Registered results |
| carry_o | output | 1 | Carry chain output |
| share_o | output | 1 | Shared-arithmetic chain output |
| rchain_o | output | 1 | Register chain output |

## Verification
The hardest case to reach is the three-operand add. Here the carry term from one bit travels on the shared chain into the next adder, and into the next cell, at the same moment as the ordinary ripple carry. Getting there takes specific table contents in two cells and both chains wired between them. The bench therefore builds sum and majority tables, cascades two cells and walks all 512 operand triples. It then adds random tables and random chain inputs in each mode, plus a directed compare sweep that exercises the carry output alone.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  parameter int unsigned LUT_K   = 4;
  parameter int unsigned NUM_LUT = 4;
  parameter int unsigned N_DATA  = 8;
  parameter int unsigned N_REG   = 2;
  localparam int unsigned TBL_W  = 1 << LUT_K;
  localparam int unsigned LUTS_W = NUM_LUT * TBL_W;
  localparam int unsigned CFG_W  = LUTS_W + 3;

  localparam int unsigned IN_A  = 0;
  localparam int unsigned IN_B  = 1;
  localparam int unsigned IN_C  = 2;
  localparam int unsigned IN_D  = 3;
  localparam int unsigned IN_E0 = 4;
  localparam int unsigned IN_F0 = 5;
  localparam int unsigned IN_E1 = 6;
  localparam int unsigned IN_F1 = 7;

  typedef enum logic [1:0] {
    MODE_NORM  = 2'b00,
    MODE_EXT   = 2'b01,
    MODE_ARITH = 2'b10,
    MODE_SHARE = 2'b11
  } cell_mode_e;

  typedef struct packed {
    logic              shift_en;
    cell_mode_e        mode;
    logic [LUTS_W-1:0] tables;
  } cell_cfg_t;
endpackage

// File: rtl/dlc_lut_bank.sv
module dlc_lut_bank #(
  parameter int unsigned K = 4,
  parameter int unsigned N = 4,
  localparam int unsigned TBL = 1 << K
) (
  input  logic [N*TBL-1:0] tables_i,
  input  logic [N*K-1:0]   idx_i,
  output logic [N-1:0]     out_o
);
  for (genvar g = 0; g < N; g++) begin : g_lut
    logic [TBL-1:0] tbl;
    logic [K-1:0]   idx;
    assign tbl      = tables_i[g*TBL +: TBL];
    assign idx      = idx_i[g*K +: K];
    assign out_o[g] = tbl[idx];
  end
endmodule

// File: rtl/dlc_adder_chain.sv
module dlc_adder_chain #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = x_i[i] ^ y_i[i];
    assign sum_o[i] = p ^ c[i];
    assign c[i+1]   = (x_i[i] & y_i[i]) | (c[i] & p);
  end
  assign cout_o = c[W];
endmodule

// File: rtl/dlc_reg_pair.sv
module dlc_reg_pair #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ena_i,
  input  logic         sclr_i,
  input  logic         sload_i,
  input  logic [W-1:0] sdata_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (ena_i) begin
      if (sclr_i)       q_o <= '0;
      else if (sload_i) q_o <= sdata_i;
      else              q_o <= d_i;
    end
  end

  assert_sclr_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && sclr_i) |=> (q_o == '0));
  assert_sload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && !sclr_i && sload_i) |=> (q_o == $past(sdata_i)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_i |=> $stable(q_o));
endmodule

// File: rtl/dual_lut_cell.sv
module dual_lut_cell
  import dlc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [N_DATA-1:0] data_i,
  input  logic              carry_i,
  input  logic              share_i,
  input  logic              rchain_i,
  input  logic              ena_i,
  input  logic              sclr_i,
  input  logic              sload_i,
  input  logic [N_REG-1:0]  sdata_i,
  output logic [N_REG-1:0]  comb_o,
  output logic [N_REG-1:0]  q_o,
  output logic              carry_o,
  output logic              share_o,
  output logic              rchain_o
);
  cell_cfg_t cfg_q;

  // configuration is captured only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= cell_cfg_t'(cfg_i);
    else         cfg_q <= cfg_q;
  end

  logic in_a, in_b, in_c, in_d, in_e0, in_f0, in_e1, in_f1;
  assign in_a  = data_i[IN_A];
  assign in_b  = data_i[IN_B];
  assign in_c  = data_i[IN_C];
  assign in_d  = data_i[IN_D];
  assign in_e0 = data_i[IN_E0];
  assign in_f0 = data_i[IN_F0];
  assign in_e1 = data_i[IN_E1];
  assign in_f1 = data_i[IN_F1];

  logic [LUT_K-1:0] idx_dcba, idx_ar0, idx_ar2, idx_sh0, idx_sh1;
  assign idx_dcba = {in_d, in_c, in_b, in_a};
  assign idx_ar0  = {in_f0, in_e0, in_b, in_a};
  assign idx_ar2  = {in_f1, in_e1, in_b, in_a};
  assign idx_sh0  = {in_e0, in_c, in_b, in_a};
  assign idx_sh1  = {in_f1, in_e1, in_d, in_f0};

  logic [NUM_LUT*LUT_K-1:0] lut_idx;
  logic [NUM_LUT-1:0]       lut_q;

  always_comb begin
    case (cfg_q.mode)
      MODE_ARITH: lut_idx = {idx_dcba, idx_ar2, idx_dcba, idx_ar0};
      MODE_SHARE: lut_idx = {idx_sh1, idx_sh1, idx_sh0, idx_sh0};
      default:    lut_idx = {NUM_LUT{idx_dcba}};
    endcase
  end

  dlc_lut_bank #(.K(LUT_K), .N(NUM_LUT)) u_luts (
    .tables_i (cfg_q.tables),
    .idx_i    (lut_idx),
    .out_o    (lut_q)
  );

  // adder operands: shared mode moves LUT1 (carry term) up one bit
  logic [1:0] add_x, add_y, add_s;
  logic       add_co;
  assign add_x = {lut_q[2], lut_q[0]};
  assign add_y = (cfg_q.mode == MODE_SHARE) ? {lut_q[1], share_i} : {lut_q[3], lut_q[1]};

  dlc_adder_chain #(.W(2)) u_add (
    .x_i    (add_x),
    .y_i    (add_y),
    .cin_i  (carry_i),
    .sum_o  (add_s),
    .cout_o (add_co)
  );

  logic norm0, norm1, ext_lo, ext_hi, ext0;
  assign norm0  = lut_q[{in_f0, in_e0}];
  assign norm1  = lut_q[{in_f1, in_e1}];
  assign ext_lo = in_e0 ? lut_q[1] : lut_q[0];
  assign ext_hi = in_e1 ? lut_q[3] : lut_q[2];
  assign ext0   = in_f0 ? ext_hi : ext_lo;

  always_comb begin
    case (cfg_q.mode)
      MODE_NORM: comb_o = {norm1, norm0};
      MODE_EXT:  comb_o = {1'b0, ext0};
      default:   comb_o = add_s;
    endcase
  end

  assign carry_o = cfg_q.mode[1] ? add_co : 1'b0;
  assign share_o = (cfg_q.mode == MODE_SHARE) ? lut_q[3] : 1'b0;

  logic             ext_kill;
  logic [N_REG-1:0] reg_d, reg_sdata;
  assign ext_kill  = (cfg_q.mode == MODE_EXT) && !cfg_q.shift_en;
  assign reg_d[0]  = cfg_q.shift_en ? rchain_i : comb_o[0];
  assign reg_d[1]  = cfg_q.shift_en ? q_o[0] : (ext_kill ? 1'b0 : comb_o[1]);
  assign reg_sdata = {sdata_i[1] & ~ext_kill, sdata_i[0]};

  dlc_reg_pair #(.W(N_REG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ena_i   (ena_i),
    .sclr_i  (sclr_i),
    .sload_i (sload_i),
    .sdata_i (reg_sdata),
    .d_i     (reg_d),
    .q_o     (q_o)
  );

  assign rchain_o = q_o[1];

  assert_cfg_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(cfg_q));
  assert_ext_reg1_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_EXT && !cfg_q.shift_en && ena_i) |=> (q_o[1] == 1'b0));
  assert_arith_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_ARITH) |->
      ({carry_o, comb_o} == 3'(lut_q[0]) + 3'(lut_q[1]) + 3'(carry_i)
                            + 3'({lut_q[2], 1'b0}) + 3'({lut_q[3], 1'b0})));
  assert_share_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_SHARE) |->
      ({carry_o, comb_o} == 3'(lut_q[0]) + 3'(share_i) + 3'(carry_i)
                            + 3'({lut_q[2], 1'b0}) + 3'({lut_q[1], 1'b0})));
  assert_shift_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.shift_en && ena_i && !sclr_i && !sload_i) |=>
      (q_o == {$past(q_o[0]), $past(rchain_i)}));
endmodule

// File: tb/dual_lut_cell_tb_top.sv
`timescale 1ns/1ps
module dual_lut_cell_tb_top;
  import dlc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [CFG_W-1:0] cfg_lo, cfg_hi;
  logic [7:0] d_lo, d_hi;
  logic cin, shin, rch, ena, sclr, sload;
  logic [1:0] sdat;
  logic [1:0] comb_lo, q_lo, comb_hi, q_hi;
  logic co_lo, sh_lo, rc_lo, co_hi, sh_hi, rc_hi;

  dual_lut_cell dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg_lo), .data_i(d_lo),
    .carry_i(cin), .share_i(shin), .rchain_i(rch), .ena_i(ena),
    .sclr_i(sclr), .sload_i(sload), .sdata_i(sdat),
    .comb_o(comb_lo), .q_o(q_lo), .carry_o(co_lo), .share_o(sh_lo), .rchain_o(rc_lo));

  dual_lut_cell dut_hi_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg_hi), .data_i(d_hi),
    .carry_i(co_lo), .share_i(sh_lo), .rchain_i(rc_lo), .ena_i(ena),
    .sclr_i(sclr), .sload_i(sload), .sdata_i(sdat),
    .comb_o(comb_hi), .q_o(q_hi), .carry_o(co_hi), .share_o(sh_hi), .rchain_o(rc_hi));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk_cfg(logic sh, logic [1:0] m, logic [63:0] t);
    return {sh, m, t};
  endfunction

  function automatic logic tbit(logic [63:0] t, int k, logic [3:0] i);
    return t[k*16 + int'(i)];
  endfunction

  function automatic logic [1:0] ref_norm(logic [63:0] t, logic [7:0] d);
    return {t[{d[7], d[6], d[3:0]}], t[{d[5], d[4], d[3:0]}]};
  endfunction

  function automatic logic ref_ext(logic [63:0] t, logic [7:0] d);
    return d[5] ? t[{1'b1, d[6], d[3:0]}] : t[{1'b0, d[4], d[3:0]}];
  endfunction

  function automatic logic [2:0] ref_arith(logic [63:0] t, logic [7:0] d, logic ci);
    int v;
    v = int'(tbit(t, 0, {d[5], d[4], d[1], d[0]})) + int'(tbit(t, 1, d[3:0])) + int'(ci)
      + 2 * (int'(tbit(t, 2, {d[7], d[6], d[1], d[0]})) + int'(tbit(t, 3, d[3:0])));
    return v[2:0];
  endfunction

  function automatic logic [3:0] ref_share(logic [63:0] t, logic [7:0] d, logic ci, logic si);
    logic [3:0] i0, i1;
    int v;
    i0 = {d[4], d[2], d[1], d[0]};
    i1 = {d[7], d[6], d[3], d[5]};
    v = int'(tbit(t, 0, i0)) + int'(si) + int'(ci)
      + 2 * (int'(tbit(t, 2, i1)) + int'(tbit(t, 1, i0)));
    return {tbit(t, 3, i1), v[2:0]};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] t, t2;
    logic [1:0] prev_exp;
    logic e0, e1;
    void'($urandom(32'h5eed_1234));
    d_lo = '0; d_hi = '0; cin = 0; shin = 0; rch = 0;
    ena = 0; sclr = 0; sload = 0; sdat = '0;
    cfg_hi = '0;

    // R10 reset state and R2 normal mode
    t = rnd64();
    cfg_lo = mk_cfg(1'b0, 2'b00, t);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 reset q", 32'(q_lo), 32'd0);
    chk("R10 reset rchain", 32'(rc_lo), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      d_lo = 8'($urandom);
      #1;
      chk("R2 normal comb", 32'(comb_lo), 32'(ref_norm(t, d_lo)));
      chk("R2 chains idle", 32'({co_lo, sh_lo}), 32'd0);
    end

    // R1 cfg changes after reset are ignored
    t2 = ~t;
    cfg_lo = mk_cfg(1'b1, 2'b11, t2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      d_lo = 8'($urandom);
      #1;
      chk("R1 cfg frozen", 32'(comb_lo), 32'(ref_norm(t, d_lo)));
    end

    // R6 registered capture alongside comb
    ena = 1;
    prev_exp = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i > 0) chk("R6 q capture", 32'(q_lo), 32'(prev_exp));
      d_lo = 8'($urandom);
      prev_exp = ref_norm(t, d_lo);
    end
    @(negedge clk);
    chk("R6 q capture last", 32'(q_lo), 32'(prev_exp));

    // R8 hold when disabled
    ena = 0;
    for (int i = 0; i < 6; i++) begin
      d_lo = 8'($urandom);
      sload = 1'(i & 1); sclr = 1'(i == 3); sdat = 2'($urandom);
      @(negedge clk);
      chk("R8 hold", 32'(q_lo), 32'(prev_exp));
    end
    sclr = 0;

    // R7 load, clear priority
    ena = 1; sload = 1; sdat = 2'b10;
    @(negedge clk);
    chk("R7 sload", 32'(q_lo), 32'h2);
    sdat = 2'b01;
    @(negedge clk);
    chk("R7 sload 01", 32'(q_lo), 32'h1);
    sclr = 1;
    @(negedge clk);
    chk("R7 sclr over sload", 32'(q_lo), 32'h0);
    sclr = 0; sdat = 2'b11;
    @(negedge clk);
    chk("R7 sload 11", 32'(q_lo), 32'h3);

    // R10 asynchronous clear mid-cycle
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R10 async clear q", 32'(q_lo), 32'd0);
    chk("R10 async clear rchain", 32'(rc_lo), 32'd0);
    sload = 0; ena = 0;

    // R9 register shift chain
    cfg_lo = mk_cfg(1'b1, 2'b00, t);
    do_reset();
    ena = 1;
    e0 = 0; e1 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9 shift q", 32'(q_lo), 32'({e1, e0}));
      chk("R9 rchain_o", 32'(rc_lo), 32'(e1));
      rch = 1'($urandom);
      d_lo = 8'($urandom);
      e1 = e0; e0 = rch;
    end
    ena = 0; rch = 0;

    // R3 extended mode
    t = rnd64();
    cfg_lo = mk_cfg(1'b0, 2'b01, t);
    do_reset();
    ena = 1; sload = 0;
    prev_exp = '0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i > 0) chk("R3 ext q", 32'(q_lo), 32'(prev_exp));
      sload = 1'(i == 30); sdat = 2'b11;
      d_lo = 8'($urandom);
      #1;
      chk("R3 ext comb", 32'(comb_lo), 32'({1'b0, ref_ext(t, d_lo)}));
      prev_exp = (i == 30) ? 2'b01 : {1'b0, ref_ext(t, d_lo)};
    end
    sload = 0; ena = 0;

    // R4 arithmetic mode random
    t = rnd64();
    cfg_lo = mk_cfg(1'b0, 2'b10, t);
    do_reset();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      d_lo = 8'($urandom); cin = 1'($urandom);
      #1;
      chk("R4 arith", 32'({co_lo, comb_lo}), 32'(ref_arith(t, d_lo, cin)));
      chk("R4 share idle", 32'(sh_lo), 32'd0);
    end

    // R4 compare via carry only
    for (int i = 0; i < 16; i++) begin
      logic [3:0] ii;
      ii = 4'(i);
      t[i]      = ii[0];
      t[16 + i] = ~ii[1];
      t[32 + i] = ii[2];
      t[48 + i] = ~ii[2];
    end
    cfg_lo = mk_cfg(1'b0, 2'b10, t);
    do_reset();
    cin = 1;
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        logic [1:0] xv, yv;
        @(negedge clk);
        xv = 2'(x); yv = 2'(y);
        d_lo = {1'b0, xv[1], 1'b0, 1'b0, 1'b0, yv[1], yv[0], xv[0]};
        #1;
        chk("R4 compare carry", 32'(co_lo), 32'(x >= y));
      end
    end

    // R5 shared-arithmetic mode random
    t = rnd64();
    cfg_lo = mk_cfg(1'b0, 2'b11, t);
    do_reset();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      d_lo = 8'($urandom); cin = 1'($urandom); shin = 1'($urandom);
      #1;
      chk("R5 shared", 32'({sh_lo, co_lo, comb_lo}), 32'(ref_share(t, d_lo, cin, shin)));
    end

    // R11 cascaded three-operand add, exhaustive (includes 6+5+2=13)
    for (int i = 0; i < 16; i++) begin
      logic [3:0] ii;
      ii = 4'(i);
      t[i]      = ii[0] ^ ii[1] ^ ii[2];
      t[16 + i] = (ii[0] & ii[1]) | (ii[0] & ii[2]) | (ii[1] & ii[2]);
      t[32 + i] = ii[1] ^ ii[2] ^ ii[3];
      t[48 + i] = (ii[1] & ii[2]) | (ii[1] & ii[3]) | (ii[2] & ii[3]);
    end
    cfg_lo = mk_cfg(1'b0, 2'b11, t);
    cfg_hi = mk_cfg(1'b0, 2'b11, t);
    cin = 0; shin = 0;
    do_reset();
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 8; y++) begin
        for (int z = 0; z < 8; z++) begin
          logic [2:0] xv, yv, zv;
          int got;
          @(negedge clk);
          xv = 3'(x); yv = 3'(y); zv = 3'(z);
          d_lo = {zv[1], yv[1], 1'b0, 1'b0, xv[1], zv[0], yv[0], xv[0]};
          d_hi = {5'b0, zv[2], yv[2], xv[2]};
          #1;
          got = int'(comb_lo[0]) + 2 * int'(comb_lo[1]) + 4 * int'(comb_hi[0])
              + 8 * int'(comb_hi[1]) + 16 * int'(co_hi);
          chk("R11 cascade add", 32'(got), 32'(x + y + z));
        end
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule